// File: doc/BRIEF.md
# SMBus Charger Command Slave

This block is the bus-facing front end of a smart battery charger. It watches the two-wire SMBus lines, answers at one fixed 7-bit device address and decodes word-sized write and read transactions into the charger's small command map. It oversamples SCL and SDA with the system clock and pulls SDA low through an open-drain style output enable.

Written words reach the charger supervisor as a one-clock strobe that carries the command code and the 16-bit value. Reads return one of two words: a fixed revision word, or a status word built from flags the supervisor supplies. A completed status read raises a strobe that the supervisor uses to clear its alert. If a host reads from the alert-response address, the block reports this only as a strobe; it does not answer.

Unsupported mode bits are dropped before they leave the block. A stop condition or a power-fail reset puts the slave back to idle at any point in a transfer.

Top module: `smb_charger_slave`

## Requirements
- R1: While `rst_n` is low, and after it rises, `sda_oe` is 0 and no strobe is raised. Asserting `rst_n` in the middle of a read releases SDA.
- R2: The slave ACKs the write address 0x12 (byte 0x24) by driving SDA low during the ninth clock. For any other address it leaves SDA released.
- R3: Bus bits are sampled on SCL rising edges. `sda_oe` changes only while SCL is low, after a falling edge.
- R4: A write word to command 0x14 or 0x15 raises `wr_stb` for exactly one clock. `wr_cmd` holds the command and `wr_data` holds the word, built from the low byte sent first and the high byte sent second.
- R5: In a write word to command 0x12, bit 0 (inhibit charge), bit 2 (power-on defaults) and bit 3 (zero the set-points) pass through to `wr_data`. Bit 1 (polling enable) and bits 15:4 are forced to 0.
- R6: A command byte other than 0x11 to 0x15 is NACKed and produces no strobe.
- R7: A read word of command 0x11 returns 0x0002: revision code 2 in bits 3:0, and the selector-support bit 4 reads 0.
- R8: A read word of command 0x13 returns, low byte first: bit 0 = `chg_inhibited_i`, bit 4 = 1 (level-2 charger), bit 8 = `cur_over_i`, bit 9 = `volt_over_i`, bit 10 = `safety_open_i`. Bits 1 to 3 (polling, voltage-not-regulated, current-not-regulated) and every other bit read 0.
- R9: After the ninth clock of the high byte of a 0x13 read, `status_rd_stb` pulses once for one clock. Other reads do not pulse it.
- R10: A stop condition in the middle of a transfer returns the slave to idle without a strobe. The next transaction is served normally.
- R11: A read addressed to 0x0C (byte 0x19) pulses `ara_stb` for one clock and is NACKed.
- R12: A read of a write-only command (0x12, 0x14, 0x15) is NACKed at the repeated-start read address. Write data to a read-only command (0x11, 0x13) is NACKed at the first data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low power-fail reset, asynchronous |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| chg_inhibited_i | input | 1 | Charging-inhibited flag for the status word |
| cur_over_i | input | 1 | Current set-point over-range flag |
| volt_over_i | input | 1 | Voltage set-point over-range flag |
| safety_open_i | input | 1 | Safety line reads as open circuit |
| wr_stb | output | 1 | One-clock pulse: a write word has completed |
| wr_cmd | output | 8 | Command code of the completed write |
| wr_data | output | 16 | Word value of the completed write, already masked |
| status_rd_stb | output | 1 | One-clock pulse: a status read has completed |
| ara_stb | output | 1 | One-clock pulse: a read to the alert-response address was seen |

## Verification
Both bus lines go through two synchronizer flops and one edge register. The action taken for an SCL edge, or for a start or stop, therefore appears on the outputs at the third clock edge after the line moves. An ACK or a read bit appears on `sda_oe` three clocks after the falling edge of SCL, and a write strobe three clocks after the falling edge that ends the high data byte.

The bench holds every SCL level for eight clocks, so each bit is settled long before the master samples it in the middle of the next high phase. Strobes are counted and captured by a monitor on the clock edge. Those tallies are compared only once the transaction has ended with its stop. The R1 and R3 checks look at `sda_oe` directly, on falling clock edges.

// File: rtl/smb_chg_pkg.sv
package smb_chg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_WLO, PH_WHI, PH_RLO, PH_RHI, PH_SKIP
  } phase_t;

  localparam logic [7:0] CMD_SPEC   = 8'h11;
  localparam logic [7:0] CMD_MODE   = 8'h12;
  localparam logic [7:0] CMD_STATUS = 8'h13;
  localparam logic [7:0] CMD_ISET   = 8'h14;
  localparam logic [7:0] CMD_VSET   = 8'h15;

  // mode bits that are forwarded: inhibit(0), defaults(2), zero set-points(3)
  localparam logic [15:0] MODE_KEEP = 16'h000D;

  function automatic logic cmd_known(input logic [7:0] c);
    return (c >= CMD_SPEC) && (c <= CMD_VSET);
  endfunction

  function automatic logic cmd_readable(input logic [7:0] c);
    return (c == CMD_SPEC) || (c == CMD_STATUS);
  endfunction

  function automatic logic cmd_writable(input logic [7:0] c);
    return (c == CMD_MODE) || (c == CMD_ISET) || (c == CMD_VSET);
  endfunction

  function automatic logic [15:0] status_word(input logic inh, input logic cor,
                                              input logic vor, input logic ror);
    logic [15:0] w;
    w     = 16'h0010;     // level-2 indication; unsupported bits stay 0
    w[0]  = inh;
    w[8]  = cor;
    w[9]  = vor;
    w[10] = ror;
    return w;
  endfunction

  function automatic logic [15:0] spec_word(input logic [3:0] rev);
    return {12'h000, rev}; // bit 4 (selector support) = 0
  endfunction

  function automatic logic [15:0] clean_write(input logic [7:0] c, input logic [15:0] d);
    return (c == CMD_MODE) ? (d & MODE_KEEP) : d;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_chg_regmap.sv
module smb_chg_regmap
  import smb_chg_pkg::*;
#(
  parameter logic [3:0] SPEC_REV = 4'h2
) (
  input  logic [7:0]  cmd,
  input  logic        inh,
  input  logic        cor,
  input  logic        vor,
  input  logic        ror,
  output logic [15:0] rd_word
);
  always_comb begin
    if (cmd == CMD_STATUS) rd_word = status_word(inh, cor, vor, ror);
    else if (cmd == CMD_SPEC) rd_word = spec_word(SPEC_REV);
    else rd_word = 16'h0000;
  end
endmodule

// File: rtl/smb_charger_slave.sv
module smb_charger_slave
  import smb_chg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h12,
  parameter logic [6:0] ARA_ADDR    = 7'h0C,
  parameter logic [3:0] SPEC_REV    = 4'h2,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic        chg_inhibited_i,
  input  logic        cur_over_i,
  input  logic        volt_over_i,
  input  logic        safety_open_i,
  output logic        wr_stb,
  output logic [7:0]  wr_cmd,
  output logic [15:0] wr_data,
  output logic        status_rd_stb,
  output logic        ara_stb
);
  localparam int BITS = 8;
  localparam logic [3:0] ACK_CNT  = 4'(BITS);
  localparam logic [3:0] SLOT_CNT = 4'(BITS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  phase_t      phase, nxt_q, nxt_c;
  logic [3:0]  cnt;
  logic [7:0]  shreg, txreg, cmd_q, lo_q;
  logic        cmd_ok, m_ack;
  logic [15:0] rd_word;

  smb_chg_regmap #(.SPEC_REV(SPEC_REV)) u_map (
    .cmd(cmd_q), .inh(chg_inhibited_i), .cor(cur_over_i),
    .vor(volt_over_i), .ror(safety_open_i), .rd_word(rd_word)
  );

  // named internal events
  logic       byte_end, slot_end, rd_phase, ack_c, ara_hit;
  logic       addr_me, addr_ara;
  logic [2:0] bidx;
  assign byte_end = scl_fall && (cnt == ACK_CNT);
  assign slot_end = scl_fall && (cnt == SLOT_CNT);
  assign rd_phase = (phase == PH_RLO) || (phase == PH_RHI);
  assign bidx     = 3'(4'd7 - cnt);
  assign addr_me  = (shreg[7:1] == DEV_ADDR);
  assign addr_ara = (shreg[7:1] == ARA_ADDR) && shreg[0];

  always_comb begin
    ack_c   = 1'b0;
    nxt_c   = PH_SKIP;
    ara_hit = 1'b0;
    case (phase)
      PH_ADDR: begin
        if (addr_me && !shreg[0]) begin
          ack_c = 1'b1; nxt_c = PH_CMD;
        end else if (addr_me && cmd_ok && cmd_readable(cmd_q)) begin
          ack_c = 1'b1; nxt_c = PH_RLO;
        end else if (addr_ara) begin
          ara_hit = 1'b1;
        end
      end
      PH_CMD: if (cmd_known(shreg)) begin ack_c = 1'b1; nxt_c = PH_WLO; end
      PH_WLO: if (cmd_writable(cmd_q)) begin ack_c = 1'b1; nxt_c = PH_WHI; end
      PH_WHI: ack_c = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; nxt_q <= PH_IDLE; cnt <= '0;
      shreg <= '0; txreg <= '0; cmd_q <= '0; lo_q <= '0;
      cmd_ok <= 1'b0; m_ack <= 1'b0; sda_oe <= 1'b0;
      wr_stb <= 1'b0; wr_cmd <= '0; wr_data <= '0;
      status_rd_stb <= 1'b0; ara_stb <= 1'b0;
    end else begin
      wr_stb        <= 1'b0;
      status_rd_stb <= 1'b0;
      ara_stb       <= 1'b0;
      if (stop_ev) begin
        phase <= PH_IDLE; cnt <= '0; sda_oe <= 1'b0; cmd_ok <= 1'b0;
      end else if (start_ev) begin
        phase <= PH_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          if (cnt < ACK_CNT) shreg <= {shreg[6:0], sda_s};
          else               m_ack <= ~sda_s;
          cnt <= cnt + 4'd1;
        end
        if (byte_end) begin
          sda_oe  <= rd_phase ? 1'b0 : ack_c;
          nxt_q   <= nxt_c;
          ara_stb <= ara_hit;
          case (phase)
            PH_CMD: begin
              cmd_ok <= cmd_known(shreg);
              if (cmd_known(shreg)) cmd_q <= shreg;
            end
            PH_WLO: lo_q <= shreg;
            PH_WHI: begin
              wr_stb  <= 1'b1;
              wr_cmd  <= cmd_q;
              wr_data <= clean_write(cmd_q, {shreg, lo_q});
            end
            default: ;
          endcase
        end else if (slot_end) begin
          cnt <= '0;
          case (phase)
            PH_RLO: begin
              if (m_ack) begin
                phase <= PH_RHI; txreg <= rd_word[15:8]; sda_oe <= ~rd_word[15];
              end else begin
                phase <= PH_SKIP; sda_oe <= 1'b0;
              end
            end
            PH_RHI: begin
              phase         <= PH_SKIP;
              sda_oe        <= 1'b0;
              status_rd_stb <= (cmd_q == CMD_STATUS);
            end
            PH_SKIP: sda_oe <= 1'b0;
            default: begin
              phase <= nxt_q;
              if (nxt_q == PH_RLO) begin
                txreg <= rd_word[7:0]; sda_oe <= ~rd_word[7];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          endcase
        end else if (scl_fall && rd_phase && cnt != 4'd0) begin
          sda_oe <= ~txreg[bidx];
        end
      end
    end
  end

  // assertions next to the logic they guard
  a_r2_foreign_addr_released: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && phase == PH_ADDR && !addr_me) |=> !sda_oe);

  a_r3_oe_moves_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  a_r4_wr_stb_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  a_r5_mode_bits_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_cmd == CMD_MODE) |-> (wr_data[1] == 1'b0 && wr_data[15:4] == 12'h000));

  a_r9_status_stb_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd_stb |-> (cmd_q == CMD_STATUS && phase == PH_SKIP));

  a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (!sda_oe && phase == PH_IDLE));

  a_r11_ara_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    ara_stb |=> !ara_stb);
endmodule

// File: tb/tb_smb_charger_slave.sv
module tb_smb_charger_slave;
  localparam int Q = 8;

  typedef struct packed {
    logic        rd;
    logic [6:0]  addr;
    logic [7:0]  cmd;
    logic [15:0] wdata;
    logic [3:0]  flags;   // [0] inhibited [1] cur over [2] volt over [3] safety open
    logic [2:0]  acks;    // expected consecutive ACKs
    logic [15:0] word;    // expected strobe data or read word
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'h12, 8'h14, 16'h1234, 4'b0000, 3'd4, 16'h1234}, // R4
    '{1'b0, 7'h12, 8'h15, 16'hBEEF, 4'b0000, 3'd4, 16'hBEEF}, // R4
    '{1'b0, 7'h12, 8'h12, 16'hFFFF, 4'b0000, 3'd4, 16'h000D}, // R5
    '{1'b0, 7'h12, 8'h12, 16'h0002, 4'b0000, 3'd4, 16'h0000}, // R5
    '{1'b0, 7'h13, 8'h14, 16'h5555, 4'b0000, 3'd0, 16'h0000}, // R2
    '{1'b0, 7'h12, 8'h20, 16'h5555, 4'b0000, 3'd1, 16'h0000}, // R6
    '{1'b1, 7'h12, 8'h11, 16'h0000, 4'b1111, 3'd3, 16'h0002}, // R7
    '{1'b1, 7'h12, 8'h13, 16'h0000, 4'b0000, 3'd3, 16'h0010}, // R8
    '{1'b1, 7'h12, 8'h13, 16'h0000, 4'b1111, 3'd3, 16'h0711}, // R8
    '{1'b1, 7'h12, 8'h13, 16'h0000, 4'b0101, 3'd3, 16'h0211}, // R8
    '{1'b1, 7'h12, 8'h14, 16'h0000, 4'b0000, 3'd2, 16'h0000}, // R12
    '{1'b0, 7'h12, 8'h13, 16'hAAAA, 4'b0000, 3'd2, 16'h0000}, // R12
    '{1'b0, 7'h12, 8'h11, 16'hAAAA, 4'b0000, 3'd2, 16'h0000}  // R12
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic inh = 0, cor = 0, vor = 0, ror = 0;
  logic sda_oe, wr_stb, status_rd_stb, ara_stb;
  logic [7:0]  wr_cmd;
  logic [15:0] wr_data;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  smb_charger_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .chg_inhibited_i(inh), .cur_over_i(cor), .volt_over_i(vor), .safety_open_i(ror),
    .wr_stb(wr_stb), .wr_cmd(wr_cmd), .wr_data(wr_data),
    .status_rd_stb(status_rd_stb), .ara_stb(ara_stb)
  );

  int n_chk = 0, n_bad = 0;
  int n_wr = 0, n_st = 0, n_ara = 0, oe_hi_moves = 0;
  logic [7:0]  cap_cmd;
  logic [15:0] cap_data;
  logic scl_d = 1'b1, oe_d = 1'b0;

  always @(posedge clk) begin
    if (wr_stb) begin n_wr++; cap_cmd <= wr_cmd; cap_data <= wr_data; end
    if (status_rd_stb) n_st++;
    if (ara_stb) n_ara++;
  end

  always @(negedge clk) begin
    if (rst_n && scl_m && scl_d && (sda_oe !== oe_d)) oe_hi_moves++;
    scl_d <= scl_m;
    oe_d  <= sda_oe;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q / 2);
    ack = ~sda_line;
    tick(Q / 2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q / 2); b[i] = sda_line; tick(Q / 2); scl_m = 1'b0;
    end
    tick(2); sda_m = ~give_ack; tick(Q - 2); scl_m = 1'b1; tick(Q); scl_m = 1'b0;
    tick(2); sda_m = 1'b1;
  endtask

  task automatic run_vec(input vec_t v, output int acks, output logic [15:0] w);
    logic a;
    logic [7:0] lo, hi;
    acks = 0; w = '0;
    bus_start();
    send_byte({v.addr, 1'b0}, a);
    if (a) begin
      acks++;
      send_byte(v.cmd, a);
      if (a) begin
        acks++;
        if (!v.rd) begin
          send_byte(v.wdata[7:0], a);
          if (a) begin acks++; send_byte(v.wdata[15:8], a); if (a) acks++; end
        end else begin
          bus_start();
          send_byte({v.addr, 1'b1}, a);
          if (a) begin
            acks++;
            recv_byte(1'b1, lo);
            recv_byte(1'b0, hi);
            w = {hi, lo};
          end
        end
      end
    end
    bus_stop();
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int acks, w0, s0;
    logic [15:0] w;
    logic a;
    tick(3);
    chk("R1 sda_oe in reset", 32'(sda_oe), 0);
    tick(3);
    rst_n = 1'b1;
    tick(10);
    chk("R1 sda_oe after reset", 32'(sda_oe), 0);
    chk("R1 no strobe after reset", 32'(n_wr + n_st + n_ara), 0);

    for (int k = 0; k < NV; k++) begin
      {ror, vor, cor, inh} = VECS[k].flags;
      w0 = n_wr; s0 = n_st;
      run_vec(VECS[k], acks, w);
      chk($sformatf("R2/R6/R12 ack count vec%0d", k), 32'(acks), 32'(VECS[k].acks));
      if (!VECS[k].rd) begin
        chk($sformatf("R4 strobe count vec%0d", k), 32'(n_wr - w0),
            (VECS[k].acks == 3'd4) ? 1 : 0);
        if (VECS[k].acks == 3'd4) begin
          chk($sformatf("R4 cmd vec%0d", k), 32'(cap_cmd), 32'(VECS[k].cmd));
          chk($sformatf("R4/R5 data vec%0d", k), 32'(cap_data), 32'(VECS[k].word));
        end
      end else begin
        if (VECS[k].acks == 3'd3)
          chk($sformatf("R7/R8 read word vec%0d", k), 32'(w), 32'(VECS[k].word));
        chk($sformatf("R9 status strobe vec%0d", k), 32'(n_st - s0),
            (VECS[k].cmd == 8'h13 && VECS[k].acks == 3'd3) ? 1 : 0);
        chk($sformatf("R12 no write from read vec%0d", k), 32'(n_wr - w0), 0);
      end
    end

    // R10: stop after the low data byte, then a clean write
    w0 = n_wr;
    bus_start();
    send_byte(8'h24, a); send_byte(8'h14, a); send_byte(8'h77, a);
    bus_stop(); tick(4);
    chk("R10 no strobe on aborted write", 32'(n_wr - w0), 0);
    run_vec(VECS[1], acks, w);
    chk("R10 next write served", 32'(n_wr - w0), 1);
    chk("R10 next write data", 32'(cap_data), 32'hBEEF);

    // R11: alert-response address read
    bus_start();
    send_byte(8'h19, a);
    bus_stop(); tick(4);
    chk("R11 ara nacked", 32'(a), 0);
    chk("R11 ara strobe", 32'(n_ara), 1);

    // R1: power-fail while the slave drives a read bit (spec word bit7 = 0)
    bus_start();
    send_byte(8'h24, a); send_byte(8'h11, a);
    bus_start();
    send_byte(8'h25, a);
    tick(Q / 2);
    chk("R1 slave driving before power-fail", 32'(sda_oe), 1);
    rst_n = 1'b0; tick(2);
    chk("R1 power-fail releases SDA", 32'(sda_oe), 0);
    rst_n = 1'b1; tick(4);
    bus_stop(); tick(4);
    run_vec(VECS[7], acks, w);
    chk("R1 served after power-fail", 32'(w), 32'h0010);

    chk("R3 sda_oe still while SCL high", 32'(oe_hi_moves), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule